// File: doc/BRIEF.md
# System Power Mode Sequencer

This block steps a small system between three clock modes. In run mode, the CPU and bus clocks come from the PLL. In direct-run mode, they come straight from the raw system clock. In halt mode, the system clock is gated off, while the low-frequency peripheral clocks keep running outside this block.

Software moves the system with two requests, suspend and resume. Enabled wake events bring a halted system back. The block drives four outputs and orders them against handshakes from the PLL and the DRAM controller:
- the clock-source select,
- the system clock enable,
- the PLL enable and its setting,
- the DRAM self-refresh request.

Halt and run are never adjacent; every path between them passes through direct-run. The PLL is touched only in direct-run. DRAM sits in self-refresh whenever the bus clocks are not sourced from a locked PLL.

Around halt, the PLL setting is saved and then zeroed. On resume it is put back, unless software wrote a new setting while in direct-run. Out of reset the block sits in direct-run with the PLL off and DRAM held in self-refresh, waiting for the first resume request.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode code is 01 (direct-run), `busy` is 0, `clkSelPll` is 0, `pllEn` is 0, `srReq` is 1, `sysClkEn` is 1 and `pllCfgOut` equals the reset setting.
- R2: A `suspendReq` seen in run idle raises `srReq` on the next cycle. The clock source stays on the PLL until `srAck` has been seen high.
- R3: After `srAck`, the block does the following in order:
  - it switches to direct-run (`clkSelPll` 0) and saves the PLL setting;
  - one cycle later it disables the PLL (`pllEn` 0, `pllCfgOut` 0);
  - on the next cycle it enters halt, with `sysClkEn` 0 and mode code 10.
- R4: The mode code never goes from 10 (halt) to 00 (run) or from 00 to 10 in one cycle.
- R5: `pllEn` and `pllCfgOut` change only on a clock edge taken while the mode code was 01.
- R6: In halt, a wake event whose enable bit is set returns the block to direct-run on the next cycle. Events whose enable bit is clear leave it in halt.
- R7: An enabled wake event that arrives outside halt is latched. The next halt then lasts exactly one cycle. Leaving halt clears the latch.
- R8: A `resumeReq` seen in direct-run idle does the following:
  - it raises `pllEn` and restores the saved setting;
  - once `pllLock` is high, it selects the PLL (mode code 00) and drops `srReq` in the same cycle;
  - it keeps `busy` high until `srAck` is low, then reaches run idle.
- R9: `cfgWr` loads `cfgIn` into `pllCfgOut` only in direct-run idle, and it is ignored in every other state. A write made after a wake takes precedence over the saved setting at the next resume.
- R10: `resumeReq` has no effect outside direct-run idle, and `suspendReq` has no effect outside run idle.
- R11: `dramClkEn` is 0 exactly when `autoStopCfg` and `srAck` are both 1.
- R12: `busy` is 1 in every sequencing state and 0 in run idle, direct-run idle and halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| suspendReq | input | 1 | Software request to suspend (honoured in run idle) |
| resumeReq | input | 1 | Software request to return to run (honoured in direct-run idle) |
| wakeEvt | input | NUM_WAKE | Wake event lines, one per source |
| wakeEn | input | NUM_WAKE | Per-source wake enable |
| cfgWr | input | 1 | Write strobe for a new PLL setting |
| cfgIn | input | CFG_W | New PLL setting |
| pllLock | input | 1 | PLL lock indication |
| srAck | input | 1 | DRAM controller self-refresh acknowledge |
| autoStopCfg | input | 1 | Stop the DRAM clock automatically while in self-refresh |
| clkSelPll | output | 1 | 1 selects the PLL as clock source, 0 the raw system clock |
| sysClkEn | output | 1 | System clock enable (0 in halt) |
| pllEn | output | 1 | PLL enable |
| pllCfgOut | output | CFG_W | PLL setting driven to the PLL |
| srReq | output | 1 | DRAM self-refresh request |
| dramClkEn | output | 1 | DRAM clock enable |
| modeCode | output | 2 | 00 run, 01 direct-run, 10 halt |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench builds the block with three wake sources, a six-bit PLL setting and a reset setting of 0x15. Three sources are enough for one enabled source, one disabled source and one source used only for latching to sit side by side. A reset setting distinct from every written value lets a restore be told apart from a write or a zero. The bench's DRAM and PLL responders answer after two and three cycles. That puts every wait state of the sequence on the trace for more than one cycle. It also lets a latched wake collapse halt to a single cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SR_ENTER,
    ST_SW_DIRECT,
    ST_PLL_OFF,
    ST_HALT,
    ST_DIRECT,
    ST_PLL_ON,
    ST_SW_RUN
  } seqState_t;

  localparam logic [1:0] MODE_RUN    = 2'b00;
  localparam logic [1:0] MODE_DIRECT = 2'b01;
  localparam logic [1:0] MODE_HALT   = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic pllOff;
    logic pllOn;
    logic cfgWrite;
    logic haltExit;
  } dpStrobe_t;

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       suspendReq,
  input  logic       resumeReq,
  input  logic       cfgWr,
  input  logic       srAck,
  input  logic       pllLock,
  input  logic       wakeHit,
  output dpStrobe_t  strobe,
  output logic       inHalt,
  output logic       clkSelPll,
  output logic       srReq,
  output logic       sysClkEn,
  output logic       busy,
  output logic [1:0] modeCode
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_DIRECT;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_RUN:       if (suspendReq) nextState = ST_SR_ENTER;
      ST_SR_ENTER:  if (srAck) nextState = ST_SW_DIRECT;
      ST_SW_DIRECT: begin
        strobe.capture = 1'b1;
        nextState      = ST_PLL_OFF;
      end
      ST_PLL_OFF: begin
        strobe.pllOff = 1'b1;
        nextState     = ST_HALT;
      end
      ST_HALT: if (wakeHit) begin
        strobe.haltExit = 1'b1;
        nextState       = ST_DIRECT;
      end
      ST_DIRECT: begin
        strobe.cfgWrite = cfgWr;
        if (resumeReq) begin
          strobe.pllOn = 1'b1;
          nextState    = ST_PLL_ON;
        end
      end
      ST_PLL_ON:    if (pllLock) nextState = ST_SW_RUN;
      ST_SW_RUN:    if (!srAck) nextState = ST_RUN;
      default:      nextState = ST_DIRECT;
    endcase
  end

  always_comb begin
    clkSelPll = (state == ST_RUN) || (state == ST_SR_ENTER) || (state == ST_SW_RUN);
    srReq     = !((state == ST_RUN) || (state == ST_SW_RUN));
    sysClkEn  = (state != ST_HALT);
    inHalt    = (state == ST_HALT);
    busy      = !((state == ST_RUN) || (state == ST_HALT) || (state == ST_DIRECT));
    if (clkSelPll)   modeCode = MODE_RUN;
    else if (inHalt) modeCode = MODE_HALT;
    else             modeCode = MODE_DIRECT;
  end

endmodule

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int NUM_WAKE = 4,
  parameter int CFG_W    = 8,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                inHalt,
  input  logic [NUM_WAKE-1:0] wakeEvt,
  input  logic [NUM_WAKE-1:0] wakeEn,
  input  logic [CFG_W-1:0]    cfgIn,
  output logic                pllEn,
  output logic [CFG_W-1:0]    pllCfgOut,
  output logic                wakeHit
);

  logic [CFG_W-1:0]    cfgReg, savedCfg;
  logic                restorePend;
  logic [NUM_WAKE-1:0] wakePend;
  logic [NUM_WAKE-1:0] wakeLive;

  assign wakeLive = wakeEvt & wakeEn;

  // per-source wake latch, armed outside halt, cleared on halt exit
  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_wake
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                         wakePend[i] <= 1'b0;
      else if (strobe.haltExit)          wakePend[i] <= 1'b0;
      else if (!inHalt && wakeLive[i])   wakePend[i] <= 1'b1;
    end
  end

  assign wakeHit = |(wakePend | wakeLive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pllEn <= 1'b0;
    end else if (strobe.pllOff) begin
      pllEn <= 1'b0;
    end else if (strobe.pllOn) begin
      pllEn <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg      <= CFG_RST;
      savedCfg    <= '0;
      restorePend <= 1'b0;
    end else begin
      if (strobe.capture) begin
        savedCfg    <= cfgReg;
        restorePend <= 1'b1;
      end else if (strobe.cfgWrite || strobe.pllOn) begin
        restorePend <= 1'b0;
      end
      if (strobe.pllOff)                       cfgReg <= '0;
      else if (strobe.cfgWrite)                cfgReg <= cfgIn;
      else if (strobe.pllOn && restorePend)    cfgReg <= savedCfg;
    end
  end

  assign pllCfgOut = cfgReg;

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_WAKE = 4,
  parameter int CFG_W    = 8,
  parameter logic [CFG_W-1:0] CFG_RST = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                suspendReq,
  input  logic                resumeReq,
  input  logic [NUM_WAKE-1:0] wakeEvt,
  input  logic [NUM_WAKE-1:0] wakeEn,
  input  logic                cfgWr,
  input  logic [CFG_W-1:0]    cfgIn,
  input  logic                pllLock,
  input  logic                srAck,
  input  logic                autoStopCfg,
  output logic                clkSelPll,
  output logic                sysClkEn,
  output logic                pllEn,
  output logic [CFG_W-1:0]    pllCfgOut,
  output logic                srReq,
  output logic                dramClkEn,
  output logic [1:0]          modeCode,
  output logic                busy
);

  dpStrobe_t strobe;
  logic      inHalt;
  logic      wakeHit;

  pwr_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .suspendReq (suspendReq),
    .resumeReq  (resumeReq),
    .cfgWr      (cfgWr),
    .srAck      (srAck),
    .pllLock    (pllLock),
    .wakeHit    (wakeHit),
    .strobe     (strobe),
    .inHalt     (inHalt),
    .clkSelPll  (clkSelPll),
    .srReq      (srReq),
    .sysClkEn   (sysClkEn),
    .busy       (busy),
    .modeCode   (modeCode)
  );

  pwr_seq_dp #(
    .NUM_WAKE (NUM_WAKE),
    .CFG_W    (CFG_W),
    .CFG_RST  (CFG_RST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inHalt    (inHalt),
    .wakeEvt   (wakeEvt),
    .wakeEn    (wakeEn),
    .cfgIn     (cfgIn),
    .pllEn     (pllEn),
    .pllCfgOut (pllCfgOut),
    .wakeHit   (wakeHit)
  );

  // DRAM clock stops while self-refresh is acknowledged, if so configured
  assign dramClkEn = !(autoStopCfg && srAck);

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clkSelPll,
  input logic             sysClkEn,
  input logic             pllEn,
  input logic [CFG_W-1:0] pllCfgOut,
  input logic             srReq,
  input logic             srAck,
  input logic             pllLock,
  input logic             autoStopCfg,
  input logic             dramClkEn,
  input logic [1:0]       modeCode,
  input logic             busy
);

  // R4
  halt_not_to_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == MODE_HALT |=> modeCode != MODE_RUN);

  // R4
  run_not_to_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == MODE_RUN |=> modeCode != MODE_HALT);

  // R5
  pll_en_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pllEn) |-> $past(modeCode) == MODE_DIRECT);

  // R5
  pll_cfg_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pllCfgOut) |-> $past(modeCode) == MODE_DIRECT);

  // R2
  sr_before_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkSelPll) |-> $past(srAck) && srReq);

  // R8
  lock_before_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSelPll) |-> $past(pllLock) && pllEn && !srReq);

  // R3
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysClkEn) |-> !pllEn && !clkSelPll && srReq);

  // R11
  dram_clk_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoStopCfg && srAck) |-> !dramClkEn);

  // R12
  busy_not_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> modeCode != MODE_HALT);

endmodule

bind pwr_mode_seq pwr_seq_chk #(.CFG_W(CFG_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .clkSelPll   (clkSelPll),
  .sysClkEn    (sysClkEn),
  .pllEn       (pllEn),
  .pllCfgOut   (pllCfgOut),
  .srReq       (srReq),
  .srAck       (srAck),
  .pllLock     (pllLock),
  .autoStopCfg (autoStopCfg),
  .dramClkEn   (dramClkEn),
  .modeCode    (modeCode),
  .busy        (busy)
);

// File: tb/pwr_mode_seq_bench.sv
`timescale 1ns/1ps
module pwr_mode_seq_bench;

  localparam int NW = 3;
  localparam int CW = 6;
  localparam logic [CW-1:0] RSTCFG = 6'h15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic suspendReq = 0, resumeReq = 0, cfgWr = 0, pllLock = 0, srAck = 1, autoStopCfg = 0;
  logic [NW-1:0] wakeEvt = '0, wakeEn = '0;
  logic [CW-1:0] cfgIn = '0;
  logic clkSelPll, sysClkEn, pllEn, srReq, dramClkEn, busy;
  logic [CW-1:0] pllCfgOut;
  logic [1:0] modeCode;

  always #4 clk = ~clk;

  pwr_mode_seq #(.NUM_WAKE(NW), .CFG_W(CW), .CFG_RST(RSTCFG)) u_pwr_mode_seq (
    .clk(clk), .rstN(rstN), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .wakeEvt(wakeEvt), .wakeEn(wakeEn), .cfgWr(cfgWr), .cfgIn(cfgIn),
    .pllLock(pllLock), .srAck(srAck), .autoStopCfg(autoStopCfg),
    .clkSelPll(clkSelPll), .sysClkEn(sysClkEn), .pllEn(pllEn),
    .pllCfgOut(pllCfgOut), .srReq(srReq), .dramClkEn(dramClkEn),
    .modeCode(modeCode), .busy(busy));

  int nChecks = 0, nFail = 0, haltCycles = 0, cycles = 0;
  int srCnt = 0, lockCnt = 0;
  bit adjacentHaltRun = 0;
  logic [1:0] prevMode = 2'b01;

  // behavioural reference: phase numbers 0 run idle, 1 waiting self-refresh,
  // 2 switched to raw clock, 3 PLL shutdown, 4 halt, 5 direct-run idle,
  // 6 waiting lock, 7 waiting self-refresh exit
  int ph;
  logic [CW-1:0] mCfg, mSaved;
  logic mRp, mPllEn;
  logic [NW-1:0] mPend;
  wire mHit = |(mPend | (wakeEvt & wakeEn));

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph <= 5; mCfg <= RSTCFG; mSaved <= '0; mRp <= 0; mPllEn <= 0; mPend <= '0;
    end else begin
      if (ph == 4 && mHit) mPend <= '0;
      else if (ph != 4)    mPend <= mPend | (wakeEvt & wakeEn);
      case (ph)
        0: if (suspendReq) ph <= 1;
        1: if (srAck) ph <= 2;
        2: begin mSaved <= mCfg; mRp <= 1; ph <= 3; end
        3: begin mPllEn <= 0; mCfg <= '0; ph <= 4; end
        4: if (mHit) ph <= 5;
        5: begin
          if (cfgWr) begin mCfg <= cfgIn; mRp <= 0; end
          if (resumeReq) begin
            mPllEn <= 1; mRp <= 0; ph <= 6;
            if (mRp && !cfgWr) mCfg <= mSaved;
          end
        end
        6: if (pllLock) ph <= 7;
        7: if (!srAck) ph <= 0;
        default: ph <= 5;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    logic [1:0] eMode;
    eMode = (ph == 0 || ph == 1 || ph == 7) ? 2'b00 : (ph == 4) ? 2'b10 : 2'b01;
    check(modeCode == eMode, "R12 mode code", modeCode, eMode);
    check(busy == !(ph == 0 || ph == 4 || ph == 5), "R12 busy", busy, !(ph == 0 || ph == 4 || ph == 5));
    check(clkSelPll == (eMode == 2'b00), "R3/R8 clock select", clkSelPll, eMode == 2'b00);
    check(srReq == !(ph == 0 || ph == 7), "R2 self-refresh request", srReq, !(ph == 0 || ph == 7));
    check(sysClkEn == (ph != 4), "R3 system clock enable", sysClkEn, ph != 4);
    check(pllEn == mPllEn, "R5 PLL enable", pllEn, mPllEn);
    check(pllCfgOut == mCfg, "R9 PLL setting", pllCfgOut, mCfg);
    check(dramClkEn == !(autoStopCfg && srAck), "R11 DRAM clock", dramClkEn, !(autoStopCfg && srAck));
  endtask

  // one clock: sample after the edge, then let the DRAM/PLL responders move
  task automatic cyc();
    @(posedge clk); #2;
    cycles++;
    compareAll();
    if (modeCode == 2'b10) haltCycles++;
    if ((prevMode == 2'b10 && modeCode == 2'b00) || (prevMode == 2'b00 && modeCode == 2'b10))
      adjacentHaltRun = 1;
    prevMode = modeCode;
    if (srReq != srAck) begin
      srCnt++;
      if (srCnt == 2) begin srAck = srReq; srCnt = 0; end
    end else srCnt = 0;
    if (!pllEn) begin pllLock = 0; lockCnt = 0; end
    else if (!pllLock) begin
      lockCnt++;
      if (lockCnt == 3) pllLock = 1;
    end
  endtask

  task automatic runN(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic pulseSuspend();
    suspendReq = 1; cyc(); suspendReq = 0;
  endtask

  task automatic pulseResume();
    resumeReq = 1; cyc(); resumeReq = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    check(modeCode == 2'b01 && busy == 0, "R1 reset mode", {modeCode, busy}, 3'b010);
    check(clkSelPll == 0 && pllEn == 0 && srReq == 1 && sysClkEn == 1, "R1 reset controls",
          {clkSelPll, pllEn, srReq, sysClkEn}, 4'b0011);
    check(pllCfgOut == RSTCFG, "R1 reset setting", pllCfgOut, RSTCFG);
    rstN = 1;
    runN(2);

    // R10 suspend in direct-run idle is ignored
    pulseSuspend(); runN(3);
    check(modeCode == 2'b01 && busy == 0, "R10 suspend ignored in direct-run", modeCode, 1);

    // R9 write in direct-run idle, then resume to run (R8)
    cfgIn = 6'h2A; cfgWr = 1; cyc(); cfgWr = 0;
    autoStopCfg = 1;
    pulseResume(); runN(12);
    check(modeCode == 2'b00 && pllCfgOut == 6'h2A, "R8 reached run with setting", pllCfgOut, 6'h2A);

    // R10 resume in run ignored; R9 write in run ignored
    pulseResume(); cfgIn = 6'h07; cfgWr = 1; cyc(); cfgWr = 0; runN(3);
    check(modeCode == 2'b00 && busy == 0, "R10 resume ignored in run", modeCode, 0);
    check(pllCfgOut == 6'h2A, "R9 write ignored in run", pllCfgOut, 6'h2A);

    // R2/R3 suspend into halt
    pulseSuspend(); runN(10);
    check(modeCode == 2'b10 && sysClkEn == 0, "R3 in halt", modeCode, 2);
    check(pllCfgOut == 0 && pllEn == 0, "R3 PLL off in halt", pllCfgOut, 0);

    // R6 disabled source ignored, then enabled source wakes
    wakeEn = 3'b001; wakeEvt = 3'b100; runN(4);
    check(modeCode == 2'b10, "R6 disabled wake ignored", modeCode, 2);
    cfgIn = 6'h3F; cfgWr = 1; cyc(); cfgWr = 0;
    check(pllCfgOut == 0, "R9 write ignored in halt", pllCfgOut, 0);
    wakeEvt = 3'b101; cyc(); wakeEvt = 3'b000;
    check(modeCode == 2'b01 && busy == 0, "R6 enabled wake to direct-run", modeCode, 1);
    runN(2);
    pulseResume();
    check(pllCfgOut == 6'h2A && pllEn == 1, "R8 setting restored", pllCfgOut, 6'h2A);
    runN(12);

    // R7 latched wake collapses the next halt to one cycle
    wakeEn = 3'b010; wakeEvt = 3'b010; cyc(); wakeEvt = 3'b000; runN(2);
    haltCycles = 0;
    pulseSuspend(); runN(12);
    check(haltCycles == 1, "R7 halt length with latched wake", haltCycles, 1);
    check(modeCode == 2'b01, "R7 back in direct-run", modeCode, 1);

    // R7 latch cleared: next halt stays until woken; R9 post-wake write wins
    pulseResume(); runN(12);
    haltCycles = 0;
    pulseSuspend(); runN(12);
    check(haltCycles >= 8 && modeCode == 2'b10, "R7 latch cleared", haltCycles, 8);
    wakeEvt = 3'b010; cyc(); wakeEvt = 3'b000;
    cfgIn = 6'h11; cfgWr = 1; cyc(); cfgWr = 0;
    pulseResume(); runN(12);
    check(pllCfgOut == 6'h11 && modeCode == 2'b00, "R9 post-wake write overrides restore", pllCfgOut, 6'h11);

    // R11 with auto stop disabled
    autoStopCfg = 0; pulseSuspend(); runN(6);
    check(dramClkEn == 1, "R11 DRAM clock kept when auto stop off", dramClkEn, 1);

    check(!adjacentHaltRun, "R4 halt and run never adjacent", adjacentHaltRun, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule